// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst to a synchronous SRAM. When a start strobe is accepted, it captures a full start address. It then changes only the two lowest address bits, one beat per clock, for as long as the active-low advance input stays low. The upper address bits keep the value captured at the start. A beat counter runs next to the address and reports which of the four beats is current.

A strobe counts as accepted only when all three chip-select inputs are in their active state. The processor-side strobe therefore has no effect while the main select is inactive. An accepted strobe always wins over advance on the same edge. The burst starts again at beat zero from the newly captured address.

A static order input chooses how the low bits step:
- Interleaved order: the start bits are XORed with the beat number.
- Linear order: the start bits are incremented modulo four.

The pad for the order input is expected to carry a pull-up, so that an open input gives interleaved order. After the fourth beat, the sequence returns to the start address if advance is still held low.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `addr` and `beat` are both zero.
- R2: On a rising edge where `sel_main_n`=0, `sel_pos`=1, `sel_neg_n`=0 and either `ld_cpu_n`=0 or `ld_ctl_n`=0, the block captures `addr_in`. After that edge, `addr` equals the captured value and `beat` equals 0.
- R3: `ld_cpu_n`=0 with `sel_main_n`=1 and `ld_ctl_n`=1 loads nothing: `addr` and `beat` keep their values or advance only as `step_n` dictates.
- R4: A strobe that arrives with `sel_pos`=0 or with `sel_neg_n`=1 loads nothing.
- R5: With no accepted strobe, `step_n`=0 increments `beat` by one per edge, and `step_n`=1 holds `beat` unchanged.
- R6: With `order_sel`=1 (interleaved), `addr[1:0]` equals the captured start bits XOR `beat`.
- R7: With `order_sel`=0 (linear), `addr[1:0]` equals the captured start bits plus `beat`, modulo 4.
- R8: Without an accepted strobe, `addr[ADDR_W-1:2]` never changes.
- R9: An advance from `beat`=3 returns `beat` to 0, and `addr` then equals the captured start address.
- R10: An accepted strobe together with `step_n`=0 on the same edge reloads. The new address appears with `beat`=0, and no step takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_main_n | input | 1 | Main chip select, active low |
| sel_pos | input | 1 | Secondary chip select, active high |
| sel_neg_n | input | 1 | Secondary chip select, active low |
| ld_cpu_n | input | 1 | Processor-side start strobe, active low |
| ld_ctl_n | input | 1 | Controller-side start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | Start address captured on an accepted strobe |
| addr | output | ADDR_W | Current beat address |
| beat | output | 2 | Current beat number, 0 to 3 |

## Verification
The stepping logic is run from two start values:
- Start bits 2 under interleaved order give 2,3,0,1.
- Start bits 3 under linear order give 3,0,1,2.

Because a plain increment and an XOR agree on some beats and differ on others, these two runs can tell a swapped or broken order function apart from a correct one. Each enable is made inactive on its own while a strobe is presented, which shows that the acceptance check needs every enable. A reload that arrives in the middle of a burst while advance is held low shows whether the reload takes priority. A burst advanced past its fourth beat, and a hold with advance high, show the wrap and the stall.

// File: rtl/bag_pkg.sv
package bag_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic main_n;
        logic pos;
        logic neg_n;
    } sel_bus_t;

    typedef struct packed {
        logic cpu_n;
        logic ctl_n;
    } strobe_bus_t;

    // Low address bits for a given beat under the selected order.
    function automatic beat_t lane_bits(beat_t start, beat_t n, order_e ord);
        beat_t r;
        if (ord == ORD_INTERLEAVE) r = start ^ n;
        else                       r = start + n;
        return r;
    endfunction

    function automatic logic all_selected(sel_bus_t s);
        return (!s.main_n) && s.pos && (!s.neg_n);
    endfunction

endpackage

// File: rtl/bag_accept.sv
module bag_accept
    import bag_pkg::*;
(
    input  sel_bus_t    sel,
    input  strobe_bus_t stb,
    output logic        accept
);
    logic any_strobe;

    always_comb begin
        any_strobe = (!stb.cpu_n) || (!stb.ctl_n);
        accept     = all_selected(sel) && any_strobe;
    end
endmodule

// File: rtl/bag_seq.sv
module bag_seq
    import bag_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              step_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] start_q,
    output beat_t             beat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            beat_q  <= '0;
        end else if (accept) begin
            start_q <= addr_in;
            beat_q  <= '0;
        end else if (!step_n) begin
            beat_q  <= beat_q + beat_t'(1);
        end
    end
endmodule

// File: rtl/bag_compose.sv
module bag_compose
    import bag_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] start_q,
    input  beat_t             beat_q,
    input  order_e            order,
    output logic [ADDR_W-1:0] addr
);
    assign addr[BEAT_W-1:0] = lane_bits(start_q[BEAT_W-1:0], beat_q, order);

    generate
        if (ADDR_W > BEAT_W) begin : g_upper
            assign addr[ADDR_W-1:BEAT_W] = start_q[ADDR_W-1:BEAT_W];
        end
    endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_main_n,
    input  logic              sel_pos,
    input  logic              sel_neg_n,
    input  logic              ld_cpu_n,
    input  logic              ld_ctl_n,
    input  logic              step_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        beat
);
    sel_bus_t          sel;
    strobe_bus_t       stb;
    logic              accept;
    logic [ADDR_W-1:0] start_q;
    beat_t             beat_q;
    order_e            order;

    assign sel   = '{main_n: sel_main_n, pos: sel_pos, neg_n: sel_neg_n};
    assign stb   = '{cpu_n: ld_cpu_n, ctl_n: ld_ctl_n};
    assign order = order_sel ? ORD_INTERLEAVE : ORD_LINEAR;

    bag_accept u_accept (
        .sel    (sel),
        .stb    (stb),
        .accept (accept)
    );

    bag_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .step_n  (step_n),
        .addr_in (addr_in),
        .start_q (start_q),
        .beat_q  (beat_q)
    );

    bag_compose #(.ADDR_W(ADDR_W)) u_compose (
        .start_q (start_q),
        .beat_q  (beat_q),
        .order   (order),
        .addr    (addr)
    );

    assign beat = beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_main_n,
    input logic              sel_pos,
    input logic              sel_neg_n,
    input logic              ld_cpu_n,
    input logic              ld_ctl_n,
    input logic              step_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        beat
);
    logic taken;
    assign taken = !sel_main_n && sel_pos && !sel_neg_n && (!ld_cpu_n || !ld_ctl_n);

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        taken |=> (addr == $past(addr_in)) && (beat == 2'd0)); // R2

    AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (rst)
        (taken && !step_n) |=> (beat == 2'd0)); // R10

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!taken && !step_n) |=> (beat == $past(beat) + 2'd1)); // R5

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!taken && step_n) |=> $stable(beat)); // R5

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        !taken |=> (addr[ADDR_W-1:2] == $past(addr[ADDR_W-1:2]))); // R8

    AST_ILV_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!taken && order_sel) |=> (!order_sel ||
            ((addr[1:0] ^ beat) == ($past(addr[1:0]) ^ $past(beat))))); // R6

    AST_LIN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!taken && !order_sel) |=> (order_sel ||
            ((addr[1:0] - beat) == ($past(addr[1:0]) - $past(beat))))); // R7
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_main_n (sel_main_n),
    .sel_pos    (sel_pos),
    .sel_neg_n  (sel_neg_n),
    .ld_cpu_n   (ld_cpu_n),
    .ld_ctl_n   (ld_ctl_n),
    .step_n     (step_n),
    .order_sel  (order_sel),
    .addr_in    (addr_in),
    .addr       (addr),
    .beat       (beat)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel_main_n, sel_pos, sel_neg_n;
    logic          ld_cpu_n, ld_ctl_n, step_n, order_sel;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr;
    logic [1:0]    beat;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst),
        .sel_main_n(sel_main_n), .sel_pos(sel_pos), .sel_neg_n(sel_neg_n),
        .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .step_n(step_n),
        .order_sel(order_sel), .addr_in(addr_in), .addr(addr), .beat(beat)
    );

    function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] n, logic ilv);
        return ilv ? (s ^ n) : (s + n);
    endfunction

    task automatic check(string req, logic [AW-1:0] ea, logic [1:0] eb);
        n_checks++;
        if (addr !== ea || beat !== eb) begin
            n_fail++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, addr, beat, ea, eb);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        sel_main_n = 1'b0; sel_pos = 1'b1; sel_neg_n = 1'b0;
        ld_cpu_n = 1'b1; ld_ctl_n = 1'b1; step_n = 1'b1;
    endtask

    task automatic load_ctl(logic [AW-1:0] a);
        idle_inputs();
        addr_in = a; ld_ctl_n = 1'b0;
        tick();
        ld_ctl_n = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1; idle_inputs(); order_sel = 1'b1; addr_in = '0;
        tick(); tick();
        check("R1 in reset", '0, 2'd0);
        rst = 1'b0;
        tick();
        check("R1 after reset", '0, 2'd0);
    endtask

    task automatic t_interleaved();
        logic [AW-1:0] st = 19'h5A3C2;
        order_sel = 1'b1;
        load_ctl(st);
        check("R2 ctl load", st, 2'd0);
        step_n = 1'b0;
        for (int i = 1; i < 4; i++) begin
            tick();
            check("R6 R8 interleaved beat", {st[AW-1:2], exp_low(st[1:0], 2'(i), 1'b1)}, 2'(i));
        end
        tick();
        check("R9 wrap to start", st, 2'd0);
        step_n = 1'b1;
        tick(); tick();
        check("R5 hold with step high", st, 2'd0);
    endtask

    task automatic t_linear();
        logic [AW-1:0] st = 19'h12347;
        order_sel = 1'b0;
        load_ctl(st);
        check("R2 ctl load linear", st, 2'd0);
        step_n = 1'b0;
        for (int i = 1; i < 4; i++) begin
            tick();
            check("R7 R8 linear beat", {st[AW-1:2], exp_low(st[1:0], 2'(i), 1'b0)}, 2'(i));
        end
        tick();
        check("R9 linear wrap", st, 2'd0);
        step_n = 1'b1;
    endtask

    task automatic t_blocked();
        logic [AW-1:0] st = 19'h0F0F1;
        order_sel = 1'b1;
        load_ctl(st);
        idle_inputs(); sel_main_n = 1'b1; ld_cpu_n = 1'b0; addr_in = 19'h7FFFF;
        tick();
        check("R3 cpu strobe blocked by main select", st, 2'd0);
        idle_inputs(); sel_pos = 1'b0; ld_ctl_n = 1'b0;
        tick();
        check("R4 sel_pos low blocks", st, 2'd0);
        idle_inputs(); sel_neg_n = 1'b1; ld_cpu_n = 1'b0;
        tick();
        check("R4 sel_neg_n high blocks", st, 2'd0);
        idle_inputs(); sel_main_n = 1'b1; ld_cpu_n = 1'b0; step_n = 1'b0;
        tick();
        check("R3 blocked strobe still steps", {st[AW-1:2], st[1:0] ^ 2'd1}, 2'd1);
        idle_inputs(); ld_cpu_n = 1'b0; addr_in = 19'h2AAA9;
        tick();
        check("R2 cpu strobe loads", 19'h2AAA9, 2'd0);
        idle_inputs();
    endtask

    task automatic t_override();
        logic [AW-1:0] st = 19'h33331;
        logic [AW-1:0] nx = 19'h44446;
        order_sel = 1'b0;
        load_ctl(st);
        step_n = 1'b0;
        tick(); tick();
        check("R7 mid burst", {st[AW-1:2], st[1:0] + 2'd2}, 2'd2);
        ld_ctl_n = 1'b0; addr_in = nx;
        tick();
        check("R10 reload beats step", nx, 2'd0);
        ld_ctl_n = 1'b1;
        tick();
        check("R10 continues from new start", {nx[AW-1:2], nx[1:0] + 2'd1}, 2'd1);
        idle_inputs();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_interleaved();
        t_linear();
        t_blocked();
        t_override();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule